// File: doc/BRIEF.md
# Parallel Port Handshake Receiver

This block is the target end of a fully interlocked four-phase handshake that carries words from a host over a 16-bit parallel bus. The host has one strobe line and the bus. The target has one status line. A low status line means the target is ready to take data. When the target sees the host pull its strobe low, it captures the bus and raises the status line to show that the read is done. The host then releases its strobe high. After that the target lowers its status line again, but only once the word it has already assembled has been handed on.

Each assembled word leaves on a valid/ready stream output. In wide mode, one handshake gives one word. In byte mode, the target takes only the low eight bits of two consecutive handshakes and joins them, with the first byte as the low half. The strobe and the bus both pass through a two-flop synchroniser before the control logic uses them. A programmable watchdog on the strobe sets a sticky error flag when the host stalls in the middle of the protocol.

Top module: `par_load_rx`

## Requirements
- R1: While `rst` is high, `tgt_rdy_n` is 1, `out_valid` is 0 and `tmo_err` is 0. On the first clock edge after `rst` falls, `tgt_rdy_n` goes to 0.
- R2: The strobe and the bus each pass through two register stages. If the strobe falls between two edges, `tgt_rdy_n` is still 0 after the next two edges and is 1 after the third.
- R3: `tgt_rdy_n` rises only on the edge at which the synchronised strobe is seen low, and the bus value is captured on that same edge.
- R4: When `byte_mode` is 0, each handshake produces one output word equal to the 16-bit bus value.
- R5: Once `tgt_rdy_n` is high, it stays high for as long as the strobe is held low. It returns to 0 on the third edge after the strobe rises, provided no word is waiting downstream.
- R6: While an output word is valid and not accepted, `tgt_rdy_n` does not return to 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R8: When `byte_mode` is 1, two handshakes produce one word. Bits 7:0 of the first transfer form bits 7:0 of the word, and bits 7:0 of the second transfer form bits 15:8. Bus bits 15:8 are ignored.
- R9: With a nonzero `tmo_limit`, `tmo_err` becomes 1 if the target waits on the same strobe level for `tmo_limit` cycles or more. Once set, it stays at 1 until reset. Setting `tmo_limit` to 0 disables the check. Waiting on a downstream consumer is never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 selects byte mode, 0 selects wide mode |
| tmo_limit | input | 16 | Stall limit in cycles, 0 disables the watchdog |
| host_strb_n | input | 1 | Host strobe, low when bus data is valid (asynchronous) |
| host_bus | input | 16 | Host data bus (asynchronous) |
| tgt_rdy_n | output | 1 | Target status line, low when ready and high when the read is complete |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Assembled output word |
| tmo_err | output | 1 | Sticky stall error |

## Verification
The assertions assume the host keeps to the protocol. The strobe is high during reset and whenever the status line is high before a capture. The bus stays stable from the moment the strobe falls until the status line rises. `byte_mode` changes only while no transfer is under way. The host model in the bench waits on the status line before every change it makes, holds the bus until the acknowledge, and changes the mode only between word boundaries. Sweeps over both modes, stalls of the consumer, and deliberate stalls of the host then check the synchroniser latency, the pairing of bytes, and the sticky timeout against values computed in the bench.

// File: rtl/par_load_pkg.sv
package par_load_pkg;
  localparam int BUS_W = 16;
  localparam int HALF_W = BUS_W / 2;

  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,
    ST_WLOW  = 2'd1,
    ST_WHIGH = 2'd2,
    ST_HOLD  = 2'd3
  } hs_state_t;
endpackage

// File: rtl/par_sync.sv
module par_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/par_stall_timer.sv
module par_stall_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          err
);
  localparam logic [TW-1:0] CNT_MAX = '1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active || restart) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else if (active && !restart && limit != '0 && cnt_q >= limit) err <= 1'b1;
  end

  p_sticky_err_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  p_no_err_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!err && limit == '0) |=> !err);
endmodule

// File: rtl/par_hs_ctrl.sv
module par_hs_ctrl
  import par_load_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_mode,
  input  logic             strb_s,
  input  logic [BUS_W-1:0] bus_s,
  input  logic             out_ready,
  output logic             rdy_n_q,
  output logic             out_valid_q,
  output logic [BUS_W-1:0] out_data_q,
  output logic             waiting,
  output logic             step
);
  hs_state_t         st_q, st_d;
  logic              phase_q;
  logic [HALF_W-1:0] lo_q;
  logic              take, word_done, pend_stays;

  assign take       = (st_q == ST_WLOW) && !strb_s;
  assign word_done  = take && (!byte_mode || phase_q);
  assign pend_stays = out_valid_q && !out_ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_BOOT:  st_d = ST_WLOW;
      ST_WLOW:  if (!strb_s) st_d = ST_WHIGH;
      ST_WHIGH: if (strb_s)  st_d = pend_stays ? ST_HOLD : ST_WLOW;
      ST_HOLD:  if (!pend_stays) st_d = ST_WLOW;
      default:  st_d = ST_BOOT;
    endcase
  end

  assign waiting = (st_q == ST_WLOW) || (st_q == ST_WHIGH);
  assign step    = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_BOOT;
      rdy_n_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_d == ST_WLOW && st_q != ST_WLOW) rdy_n_q <= 1'b0;
      else if (take)                          rdy_n_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      lo_q    <= '0;
    end else if (take) begin
      if (byte_mode && !phase_q) begin
        lo_q    <= bus_s[HALF_W-1:0];
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
      end
    end else if (!byte_mode) begin
      phase_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (out_valid_q && out_ready) out_valid_q <= 1'b0;
      if (word_done) begin
        out_valid_q <= 1'b1;
        out_data_q  <= byte_mode ? {bus_s[HALF_W-1:0], lo_q} : bus_s;
      end
    end
  end

  p_ack_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n_q) |-> $past(!strb_s));
  p_ready_after_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n_q) |-> $past(strb_s));
  p_no_ready_pending_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n_q) |-> $past(!out_valid_q || out_ready));
  p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_data_q)));
endmodule

// File: rtl/par_load_rx.sv
module par_load_rx
  import par_load_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_mode,
  input  logic [TW-1:0]    tmo_limit,
  input  logic             host_strb_n,
  input  logic [BUS_W-1:0] host_bus,
  output logic             tgt_rdy_n,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_data,
  output logic             tmo_err
);
  localparam int SYNC_W = BUS_W + 1;

  logic [SYNC_W-1:0] sync_q;
  logic              waiting, step;

  par_sync #(.W(SYNC_W), .STAGES(2), .RST_VAL({1'b1, {BUS_W{1'b0}}})) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_strb_n, host_bus}),
    .q   (sync_q)
  );

  par_hs_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .byte_mode   (byte_mode),
    .strb_s      (sync_q[BUS_W]),
    .bus_s       (sync_q[BUS_W-1:0]),
    .out_ready   (out_ready),
    .rdy_n_q     (tgt_rdy_n),
    .out_valid_q (out_valid),
    .out_data_q  (out_data),
    .waiting     (waiting),
    .step        (step)
  );

  par_stall_timer #(.TW(TW)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .active  (waiting),
    .restart (step),
    .limit   (tmo_limit),
    .err     (tmo_err)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (tgt_rdy_n && !out_valid && !tmo_err) || !rst);
endmodule

// File: tb/sim_par_load_rx.sv
module sim_par_load_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_mode = 1'b0;
  logic [15:0] tmo_limit = '0;
  logic        host_strb_n = 1'b1;
  logic [15:0] host_bus = '0;
  logic        out_ready = 1'b1;
  logic        tgt_rdy_n, out_valid, tmo_err;
  logic [15:0] out_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] rx_mem [0:127];
  int rx_cnt = 0;

  always #2.5 clk = ~clk;

  par_load_rx u0 (
    .clk(clk), .rst(rst), .byte_mode(byte_mode), .tmo_limit(tmo_limit),
    .host_strb_n(host_strb_n), .host_bus(host_bus), .tgt_rdy_n(tgt_rdy_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tmo_err(tmo_err)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      rx_mem[rx_cnt[6:0]] = out_data;
      rx_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic wait_rdy(input logic lvl);
    while (tgt_rdy_n !== lvl) @(negedge clk);
  endtask

  task automatic host_xfer(input logic [15:0] v);
    wait_rdy(1'b0);
    @(negedge clk);
    host_bus = v;
    host_strb_n = 1'b0;
    wait_rdy(1'b1);
    @(negedge clk);
    host_strb_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    idle(3);
    check("R1 rdy in reset", tgt_rdy_n, 1);
    check("R1 valid in reset", out_valid, 0);
    check("R1 err in reset", tmo_err, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", tgt_rdy_n, 0);

    // R2 / R3 / R5 exact latency
    @(negedge clk);
    host_bus = 16'hBEEF;
    host_strb_n = 1'b0;
    idle(2);
    check("R2 still ready after two edges", tgt_rdy_n, 0);
    idle(1);
    check("R3 ack on third edge", tgt_rdy_n, 1);
    idle(10);
    check("R5 ack held while strobe low", tgt_rdy_n, 1);
    host_strb_n = 1'b1;
    idle(2);
    check("R5 ack until release synced", tgt_rdy_n, 1);
    idle(1);
    check("R5 ready on third edge after release", tgt_rdy_n, 0);
    check("R4 word count", rx_cnt, 1);
    check("R4 captured word", rx_mem[0], 16'hBEEF);

    // R4 sweep in wide mode
    base = rx_cnt;
    for (int i = 0; i < 64; i++) host_xfer(16'(i * 16'h9E37 + 16'h1234) ^ 16'(1 << (i % 16)));
    idle(6);
    check("R4 sweep count", rx_cnt - base, 64);
    for (int i = 0; i < 64; i++)
      check("R4 sweep word", rx_mem[base + i], 16'(i * 16'h9E37 + 16'h1234) ^ 16'(1 << (i % 16)));
    check("R9 disabled limit", tmo_err, 0);

    // R6 / R7 backpressure
    out_ready = 1'b0;
    base = rx_cnt;
    host_xfer(16'h5A3C);
    idle(20);
    check("R6 not ready while pending", tgt_rdy_n, 1);
    check("R7 valid held", out_valid, 1);
    check("R7 data held", out_data, 16'h5A3C);
    out_ready = 1'b1;
    idle(4);
    check("R6 ready after accept", tgt_rdy_n, 0);
    check("R7 word delivered once", rx_cnt - base, 1);
    check("R7 word value", rx_mem[base], 16'h5A3C);

    // R8 byte mode sweep, upper bus bits carry junk
    byte_mode = 1'b1;
    base = rx_cnt;
    for (int i = 0; i < 32; i++) begin
      host_xfer({8'(8'hC3 ^ i), 8'(i * 37 ^ 8'h5A)});
      host_xfer({8'(8'h3C + i), 8'(~(i * 11))});
    end
    idle(6);
    check("R8 byte word count", rx_cnt - base, 32);
    for (int i = 0; i < 32; i++)
      check("R8 byte pairing", rx_mem[base + i], {8'(~(i * 11)), 8'(i * 37 ^ 8'h5A)});

    // R8 with backpressure across a byte pair
    out_ready = 1'b0;
    base = rx_cnt;
    host_xfer(16'hFF11);
    idle(5);
    check("R8 first byte gives no word", out_valid, 0);
    host_xfer(16'hEE22);
    idle(5);
    check("R8 pair under stall", out_data, 16'h2211);
    check("R6 held in byte mode", tgt_rdy_n, 1);
    out_ready = 1'b1;
    idle(4);
    check("R8 delivered", rx_cnt - base, 1);
    byte_mode = 1'b0;

    // R9 timeout
    rst = 1'b1;
    tmo_limit = 16'd40;
    idle(2);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) host_xfer(16'(i + 7));
    idle(2);
    check("R9 no false timeout", tmo_err, 0);
    idle(60);
    check("R9 stall detected", tmo_err, 1);
    host_xfer(16'h0101);
    idle(4);
    check("R9 sticky", tmo_err, 1);
    finish_run();
  end
endmodule